// File: doc/BRIEF.md
# Half-Duplex Transmit Outcome Tracker

This block follows one Ethernet transmit attempt sequence, from the strobe that opens a frame to the point where the frame is either sent or given up. While the attempt runs, it counts early collisions and asks for a retry after each one. It watches for a collision that arrives too deep into the frame and for a collision count that grows too large. It times contiguous deferral in bit times and notes whether carrier sense ever dropped. When the attempt ends, it presents an 11-bit outcome word with a one-cycle valid strobe. An abort strobe is raised alongside the valid strobe when the attempt was abandoned.

A small controller drives the block. There are three states. IDLE waits for `frame_start`, and that strobe moves the block to SEND while clearing every flag and counter. SEND collects events. It moves to REPORT when the frame completes or when an abort condition arises. REPORT lasts one cycle, drives `status_valid`, and returns to IDLE. The outcome word holds its value in IDLE until the next `frame_start`. When `full_duplex` is high, collisions, deferral and carrier loss are all ignored.

Outcome word layout: bit 0 deferred, bit 1 reserved (0), bit 2 excessive deferral, bits 6:3 collision count, bit 7 reserved (0), bit 8 excessive collisions, bit 9 late collision, bit 10 carrier lost.

Top module: `tx_outcome_tracker`

## Requirements
- R1: After reset, `status_word`, `status_valid`, `abort_req` and `retry_req` are all 0.
- R2: In SEND, a `frame_end` with no collision in the same cycle sets `status_valid` for exactly one cycle, starting the cycle after the strobe, with `abort_req` 0. The word stays unchanged afterwards until the next `frame_start`.
- R3: A collision in SEND while `byte_count` < 64 increments bits 6:3 and raises `retry_req` for one cycle, starting the next cycle. A collision in the same cycle as `frame_end` takes precedence over it.
- R4: When 15 collisions have already been counted, the next collision sets bit 8 and raises `abort_req` with `status_valid`. It gives no retry, and bits 6:3 stay saturated at 15.
- R5: A collision while `byte_count` >= 64 sets bit 9 and aborts, and it does not add to bits 6:3. A collision at 63 bytes is an early collision.
- R6: Bit 0 is set when `defer_active` is high in any SEND cycle.
- R7: With `defer_chk_en` high, the 24289th consecutive `bit_tick` while `defer_active` is held sets bit 2 and aborts. Exactly 24288 ticks do not abort, and with `defer_chk_en` low there is never an abort for deferral.
- R8: Bit 10 is set when `carrier_ok` is low in any SEND cycle.
- R9: Bits 1 and 7 always read 0.
- R10: With `full_duplex` high, collisions, deferral and carrier loss are ignored. No retry or abort occurs, and bits 0, 2, 3 to 6, 8, 9 and 10 report 0.
- R11: A `frame_start` in IDLE clears the outcome word to 0 by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Opens a transmit attempt (IDLE only) |
| frame_end | input | 1 | Frame sent successfully |
| coll_pulse | input | 1 | Collision seen this cycle |
| carrier_ok | input | 1 | Carrier sense present |
| byte_count | input | 16 | Bytes of the frame sent so far |
| bit_tick | input | 1 | One pulse per bit time |
| defer_active | input | 1 | Transmitter is deferring |
| full_duplex | input | 1 | Full-duplex mode |
| defer_chk_en | input | 1 | Enables the excessive-deferral abort |
| status_word | output | 11 | Packed outcome word |
| status_valid | output | 1 | Outcome word presented (one cycle) |
| abort_req | output | 1 | Attempt abandoned (with status_valid) |
| retry_req | output | 1 | Early collision, retry requested |

## Verification
The bench pushes the collision count to its edge: fifteen early collisions and then a sixteenth. A counter that wrapped would report a small count with no abort, and a design that was off by one would abort a collision too early or too late. It places collisions at 63 and at 64 bytes, which exposes a boundary comparison written with the wrong operator. It drives deferral for exactly the limit and for one tick more, and once more with the check disabled, so that an off-by-one or an ignored enable shows up as a wrong abort. Full-duplex runs with every disturbing input active catch gating that was left out, and a new frame after a flagged one catches flags that were not cleared.

// File: rtl/txst_pkg.sv
package txst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_REPORT = 2'd2
    } txst_state_e;

    localparam int unsigned CNT_FIELD_W = 4;

    typedef struct packed {
        logic                   carrier_lost;  // bit 10
        logic                   late_coll;     // bit 9
        logic                   excess_coll;   // bit 8
        logic                   rsv_hi;        // bit 7
        logic [CNT_FIELD_W-1:0] coll_count;    // bits 6:3
        logic                   excess_defer;  // bit 2
        logic                   rsv_lo;        // bit 1
        logic                   deferred;      // bit 0
    } txst_word_t;

endpackage

// File: rtl/txst_coll_count.sv
module txst_coll_count #(
    parameter int unsigned MAX_COLL = 16,
    localparam int unsigned CNT_W   = $clog2(MAX_COLL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_COLL - 1);

    assign at_limit = (count == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (hit && !at_limit)
            count <= count + 1'b1;
    end

    // R3: an early collision below the limit adds exactly one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear && count != TOP) |=> (count == $past(count) + 1'b1));

    // R4: once saturated, the count stays put until cleared
    assert_count_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clear) |=> (count == TOP));

endmodule

// File: rtl/txst_defer_timer.sv
module txst_defer_timer #(
    parameter int unsigned LIMIT = 24288,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic tick,
    output logic expire
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] ticks;

    assign expire = active && tick && (ticks == LIM);

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !active)
            ticks <= '0;
        else if (tick && ticks != LIM)
            ticks <= ticks + 1'b1;
    end

    // R7: the run length never climbs past the limit
    assert_ticks_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ticks <= LIM);

    // R7: dropping deferral restarts the run
    assert_restart_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ticks == '0));

endmodule

// File: rtl/tx_outcome_tracker.sv
module tx_outcome_tracker
    import txst_pkg::*;
#(
    parameter int unsigned BYTE_W      = 16,
    parameter int unsigned LATE_BYTES  = 64,
    parameter int unsigned MAX_COLL    = 16,
    parameter int unsigned DEFER_LIMIT = 24288,
    localparam int unsigned STATUS_W   = $bits(txst_word_t)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_end,
    input  logic                coll_pulse,
    input  logic                carrier_ok,
    input  logic [BYTE_W-1:0]   byte_count,
    input  logic                bit_tick,
    input  logic                defer_active,
    input  logic                full_duplex,
    input  logic                defer_chk_en,
    output logic [STATUS_W-1:0] status_word,
    output logic                status_valid,
    output logic                abort_req,
    output logic                retry_req
);
    localparam logic [BYTE_W-1:0] LATE_AT = BYTE_W'(LATE_BYTES);

    txst_state_e state_q, state_d;

    logic half, in_send, clear_ev;
    logic coll_ev, late_ev, early_ev, excess_ev, retry_ev;
    logic defer_exp, timer_exp, abort_ev, done_ev;
    logic coll_at_limit;
    logic [CNT_FIELD_W-1:0] coll_cnt;

    logic f_deferred, f_exc_defer, f_exc_coll, f_late, f_no_carrier;
    logic valid_q, abort_q, retry_q;

    // event decode
    assign half      = !full_duplex;
    assign in_send   = (state_q == ST_SEND);
    assign clear_ev  = (state_q == ST_IDLE) && frame_start;
    assign coll_ev   = in_send && half && coll_pulse;
    assign late_ev   = coll_ev && (byte_count >= LATE_AT);
    assign early_ev  = coll_ev && !late_ev;
    assign excess_ev = early_ev && coll_at_limit;
    assign retry_ev  = early_ev && !coll_at_limit;
    assign defer_exp = in_send && half && defer_chk_en && timer_exp;
    assign abort_ev  = late_ev || excess_ev || defer_exp;
    assign done_ev   = in_send && frame_end && !coll_ev && !defer_exp;

    txst_coll_count #(.MAX_COLL(MAX_COLL)) u_coll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_ev),
        .hit      (early_ev),
        .count    (coll_cnt),
        .at_limit (coll_at_limit)
    );

    txst_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_ev),
        .active (in_send && half && defer_active),
        .tick   (bit_tick),
        .expire (timer_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start)          state_d = ST_SEND;
            ST_SEND:   if (abort_ev || done_ev)  state_d = ST_REPORT;
            ST_REPORT:                           state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n || clear_ev) begin
            f_deferred   <= 1'b0;
            f_exc_defer  <= 1'b0;
            f_exc_coll   <= 1'b0;
            f_late       <= 1'b0;
            f_no_carrier <= 1'b0;
            valid_q      <= 1'b0;
            abort_q      <= 1'b0;
            retry_q      <= 1'b0;
        end else begin
            if (in_send && half && defer_active) f_deferred   <= 1'b1;
            if (in_send && half && !carrier_ok)  f_no_carrier <= 1'b1;
            if (late_ev)   f_late      <= 1'b1;
            if (excess_ev) f_exc_coll  <= 1'b1;
            if (defer_exp) f_exc_defer <= 1'b1;
            valid_q <= abort_ev || done_ev;
            abort_q <= abort_ev;
            retry_q <= retry_ev;
        end
    end

    txst_word_t word;
    always_comb begin
        word              = '0;
        word.deferred     = f_deferred;
        word.excess_defer = f_exc_defer;
        word.coll_count   = coll_cnt;
        word.excess_coll  = f_exc_coll;
        word.late_coll    = f_late;
        word.carrier_lost = f_no_carrier;
    end

    assign status_word  = word;
    assign status_valid = valid_q;
    assign abort_req    = abort_q;
    assign retry_req    = retry_q;

    initial assert_count_fits_R4: assert (MAX_COLL <= (1 << CNT_FIELD_W));

    // R2: the outcome strobe lasts one cycle
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid);

    // R4: an abort is only ever reported together with the outcome
    assert_abort_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> status_valid);

    // R4: excessive collisions always end in an abort
    assert_excess_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status_word[8]) |-> abort_req);

    // R5: a late collision always ends in an abort
    assert_late_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status_word[9]) |-> abort_req);

    // R3: a retry never coincides with the final outcome
    assert_retry_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> !status_valid);

    // R2: the word holds steady while waiting for the next frame
    assert_word_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_start) |=> $stable(status_word));

endmodule

// File: tb/sim_tx_outcome_tracker.sv
module sim_tx_outcome_tracker;

    localparam int LIMIT = 24288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 0, frame_end = 0, coll_pulse = 0;
    logic        carrier_ok = 1, bit_tick = 0, defer_active = 0;
    logic        full_duplex = 0, defer_chk_en = 0;
    logic [15:0] byte_count = '0;
    logic [10:0] status_word;
    logic        status_valid, abort_req, retry_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tx_outcome_tracker u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .coll_pulse(coll_pulse), .carrier_ok(carrier_ok), .byte_count(byte_count),
        .bit_tick(bit_tick), .defer_active(defer_active), .full_duplex(full_duplex),
        .defer_chk_en(defer_chk_en), .status_word(status_word),
        .status_valid(status_valid), .abort_req(abort_req), .retry_req(retry_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic open_frame();
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
    endtask

    task automatic close_frame();
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
    endtask

    task automatic collide(input int bytes);
        byte_count = 16'(bytes);
        coll_pulse = 1;
        @(negedge clk);
        coll_pulse = 0;
    endtask

    task automatic t_reset();
        eq("R1 word", status_word, 0);
        eq("R1 valid", status_valid, 0);
        eq("R1 abort", abort_req, 0);
        eq("R1 retry", retry_req, 0);
    endtask

    task automatic t_clean();
        open_frame();
        close_frame();
        eq("R2 valid", status_valid, 1);
        eq("R2 abort", abort_req, 0);
        eq("R2 word", status_word, 0);
        @(negedge clk);
        eq("R2 valid one cycle", status_valid, 0);
        repeat (3) @(negedge clk);
        eq("R2 word held", status_word, 0);
    endtask

    task automatic t_few_coll();
        open_frame();
        for (int i = 0; i < 3; i++) begin
            collide(10);
            eq("R3 retry", retry_req, 1);
        end
        // collision and end together: collision wins
        frame_end = 1; byte_count = 20; coll_pulse = 1;
        @(negedge clk);
        frame_end = 0; coll_pulse = 0;
        eq("R3 collision over end", status_valid, 0);
        eq("R3 retry on tie", retry_req, 1);
        close_frame();
        eq("R3 valid", status_valid, 1);
        eq("R3 count field", int'(status_word[6:3]), 4);
        eq("R3 abort", abort_req, 0);
        eq("R9 reserved", int'({status_word[7], status_word[1]}), 0);
        @(negedge clk);
    endtask

    task automatic t_excess();
        open_frame();
        eq("R11 cleared", status_word, 0);
        for (int i = 0; i < 15; i++) collide(5);
        eq("R4 no abort at 15", status_valid, 0);
        eq("R4 count 15", int'(status_word[6:3]), 15);
        collide(5);
        eq("R4 valid", status_valid, 1);
        eq("R4 abort", abort_req, 1);
        eq("R4 excess bit", status_word[8], 1);
        eq("R4 no retry", retry_req, 0);
        eq("R4 saturated", int'(status_word[6:3]), 15);
        @(negedge clk);
    endtask

    task automatic t_late();
        open_frame();
        eq("R11 cleared after excess", status_word, 0);
        collide(63);
        eq("R5 63 bytes early", retry_req, 1);
        eq("R5 63 bytes no abort", status_valid, 0);
        collide(64);
        eq("R5 valid", status_valid, 1);
        eq("R5 abort", abort_req, 1);
        eq("R5 late bit", status_word[9], 1);
        eq("R5 count unchanged", int'(status_word[6:3]), 1);
        eq("R5 no excess", status_word[8], 0);
        @(negedge clk);
    endtask

    task automatic t_defer_edge();
        defer_chk_en = 1;
        open_frame();
        defer_active = 1; bit_tick = 1;
        repeat (LIMIT) @(negedge clk);
        eq("R7 limit no abort", status_valid, 0);
        defer_active = 0; bit_tick = 0;
        @(negedge clk);
        close_frame();
        eq("R7 valid", status_valid, 1);
        eq("R7 abort", abort_req, 0);
        eq("R7 no excess defer", status_word[2], 0);
        eq("R6 deferred bit", status_word[0], 1);
        @(negedge clk);
    endtask

    task automatic t_defer_over();
        defer_chk_en = 1;
        open_frame();
        defer_active = 1; bit_tick = 1;
        repeat (LIMIT) @(negedge clk);
        eq("R7 before expiry", status_valid, 0);
        @(negedge clk);
        defer_active = 0; bit_tick = 0;
        eq("R7 expiry valid", status_valid, 1);
        eq("R7 expiry abort", abort_req, 1);
        eq("R7 excess defer bit", status_word[2], 1);
        @(negedge clk);
    endtask

    task automatic t_defer_off();
        defer_chk_en = 0;
        open_frame();
        defer_active = 1; bit_tick = 1;
        repeat (LIMIT + 5) @(negedge clk);
        defer_active = 0; bit_tick = 0;
        eq("R7 disabled no abort", status_valid, 0);
        close_frame();
        eq("R7 disabled abort", abort_req, 0);
        eq("R7 disabled bit2", status_word[2], 0);
        eq("R6 deferred when disabled", status_word[0], 1);
        @(negedge clk);
    endtask

    task automatic t_carrier();
        open_frame();
        carrier_ok = 0;
        @(negedge clk);
        carrier_ok = 1;
        close_frame();
        eq("R8 carrier bit", status_word[10], 1);
        eq("R8 other bits", int'(status_word[9:0]), 0);
        @(negedge clk);
    endtask

    task automatic t_full_duplex();
        full_duplex = 1; defer_chk_en = 1;
        open_frame();
        carrier_ok = 0; defer_active = 1; bit_tick = 1;
        collide(10);
        eq("R10 no retry", retry_req, 0);
        collide(100);
        eq("R10 no abort on late", status_valid, 0);
        carrier_ok = 1; defer_active = 0; bit_tick = 0;
        close_frame();
        eq("R10 valid", status_valid, 1);
        eq("R10 abort", abort_req, 0);
        eq("R10 word zero", status_word, 0);
        full_duplex = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_clean();
        t_few_coll();
        t_excess();
        t_late();
        t_carrier();
        t_defer_edge();
        t_defer_over();
        t_defer_off();
        t_full_duplex();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule